// File: doc/BRIEF.md
# Multicycle Sixteen-Bit Register Processor

This block is a small 16-bit processor. It runs each instruction as a fixed sequence of register transfers, one transfer per clock. It has eight general registers, a 10-bit program counter, an instruction register, an address register, a write-data register, a scratch ALU register and two condition flags: zero and sign. It drives a 1024-word synchronous memory. The address and write-data come from its own registers, a write strobe marks a store, and read data returns one clock after the address is presented. Because the memory's output register serves as the read-data holding stage, no separate read register is needed.

Each instruction starts with a three-clock fetch. Then comes a fixed number of execute clocks that depends only on the decoded instruction, so every opcode has an exact cycle count. A subroutine call pushes its return address through register 7 as a stack pointer, and a return pops it. The processor also has a register-linked jump that reads its 10-bit target from the word after the instruction, and a jump through a register. A call to address 1000 stops the processor. A free-running clock counter lets a test environment measure per-instruction timing and total run time.

Top module: `mc16_cpu`

## Requirements
- R1: When synchronous active-high `rst` is high, PC, all registers, both flags, `halted` and `cycle_count` are cleared. The first fetch after reset reads address 0.
- R2: A fetch takes three clocks. `mem_addr` equals the PC during the fetch's second clock. The fetched word is loaded into the instruction register, and the PC advances by one (modulo 1024).
- R3: Primary format: bits 15:13 opcode, 12:10 register, 9:0 address. Opcode 0 loads the register from memory at the address (6 clocks). Opcode 1 stores the register to that address (6 clocks). The write strobe is high for exactly one clock, the sixth.
- R4: Extended format: bits 15:13 = 7, bits 12:9 sub-opcode, bits 8:6 zero, bits 5:3 ra, bits 2:0 rb. Sub-opcode 0 copies ra into rb. Sub-opcode 3 sets ra = ra + rb. Sub-opcode 5 sets ra = ra + 1. Each takes 5 clocks.
- R5: Sub-opcode 1 loads rb from memory at ra. Sub-opcode 2 writes ra to memory at rb, with the strobe on the sixth clock. Both take 6 clocks. Only the low 10 bits of the address register are used.
- R6: Sub-opcode 4 (4 clocks) compares ra with rb as signed 16-bit values. It sets zero when they are equal and sign when ra < rb, with overflow accounted for. Opcode 2 (5 clocks) loads the PC from the address field when the condition in bits 12:10 holds: 0 always, 1 zero, 2 not zero, 3 less, 4 less-or-equal, 5 greater-or-equal, 6 greater, 7 never.
- R7: Opcode 3 (9 clocks) increments register 7. It then writes the already-advanced PC to memory at the new register 7, with the strobe on the eighth clock, and loads the PC from the address field. Sub-opcode 6 (8 clocks) loads the PC from memory at register 7 and then decrements register 7.
- R8: Sub-opcode 7 (6 clocks) reads the next word as the target. It writes (address of that word + 1) into ra and loads the PC from the target's low 10 bits. Sub-opcode 8 (4 clocks) loads the PC from the low 10 bits of ra.
- R9: Opcodes 4–6, sub-opcodes 9–15, and extended words whose bits 8:6 are not zero are no-ops. They cost only the 3 fetch clocks and change no state.
- R10: A call to address 1000 completes normally and then raises `halted`. After that, every register, the counter and the memory interface are frozen, and no write occurs.
- R11: `cycle_count` increments on every clock while not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 10 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, registered one clock after the address |
| mem_we | output | 1 | Memory write strobe |
| halted | output | 1 | High once the processor has stopped |
| cycle_count | output | 32 | Clocks elapsed since reset while running |

## Verification
Two events share one clock. The final clock of a call to the stop address both loads the PC and raises `halted`, and `halted` in turn freezes the cycle counter. The bench ends each run this way. It expects the stack write on the eighth clock of that call and `halted` to rise after the ninth, and it then checks that the counter holds its value for several clocks with the strobe low. A second situation involves a return: its last two clocks adjust register 7 after the PC has already been reloaded from the stack. Any overlap error there shows up in a later stack write address, which the bench compares on every clock.

// File: rtl/mc16_cpu.sv
module mc16_cpu #(
  parameter int CW        = 32,
  parameter int HALT_ADDR = 1000
)(
  input  logic          clk,
  input  logic          rst,
  output logic [9:0]    mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          mem_we,
  output logic          halted,
  output logic [CW-1:0] cycle_count
);
  localparam int AW = 10;
  localparam int NR = 8;
  localparam logic [3:0] FETCH_LAST = 4'd2;
  localparam logic [3:0] EX0 = 4'd3;

  typedef enum logic [3:0] {
    K_LD, K_ST, K_JMP, K_CALL, K_MOV, K_LDR, K_STR,
    K_ADD, K_CMP, K_INC, K_RET, K_JAL, K_JR, K_NOP
  } kind_t;

  function automatic kind_t decode(input logic [15:0] w);
    kind_t k;
    k = K_NOP;
    case (w[15:13])
      3'd0: k = K_LD;
      3'd1: k = K_ST;
      3'd2: k = K_JMP;
      3'd3: k = K_CALL;
      3'd7: if (w[8:6] == 3'd0)
        case (w[12:9])
          4'd0: k = K_MOV;
          4'd1: k = K_LDR;
          4'd2: k = K_STR;
          4'd3: k = K_ADD;
          4'd4: k = K_CMP;
          4'd5: k = K_INC;
          4'd6: k = K_RET;
          4'd7: k = K_JAL;
          4'd8: k = K_JR;
          default: k = K_NOP;
        endcase
      default: k = K_NOP;
    endcase
    return k;
  endfunction

  function automatic logic [3:0] exec_len(input kind_t k);
    case (k)
      K_LD, K_ST, K_LDR, K_STR, K_JAL: return 4'd3;
      K_JMP, K_MOV, K_ADD, K_INC:      return 4'd2;
      K_CMP, K_JR:                     return 4'd1;
      K_CALL:                          return 4'd6;
      K_RET:                           return 4'd5;
      default:                         return 4'd0;
    endcase
  endfunction

  logic [AW-1:0] pc, mar;
  logic [15:0]   mdr, ir, t;
  logic [15:0]   rf [NR];
  logic          zf, sf;
  logic [3:0]    step, nstep, ex, xl;
  kind_t         kind;

  wire [2:0]    ra  = ir[12:10];
  wire [2:0]    r1  = ir[5:3];
  wire [2:0]    r2  = ir[2:0];
  wire [AW-1:0] ads = ir[9:0];
  wire [16:0]   diff = {rf[r1][15], rf[r1]} - {rf[r2][15], rf[r2]};

  assign kind = decode(ir);
  assign xl   = exec_len(kind);
  assign ex   = step - EX0;

  logic take;
  always_comb
    case (ra)
      3'd0: take = 1'b1;
      3'd1: take = zf;
      3'd2: take = !zf;
      3'd3: take = sf;
      3'd4: take = sf || zf;
      3'd5: take = !sf;
      3'd6: take = !sf && !zf;
      default: take = 1'b0;
    endcase

  always_comb
    if (step < FETCH_LAST)       nstep = step + 4'd1;
    else if (step == FETCH_LAST) nstep = (exec_len(decode(mem_rdata)) == 4'd0) ? 4'd0 : EX0;
    else                         nstep = (ex == xl - 4'd1) ? 4'd0 : step + 4'd1;

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_we    = !halted && step >= EX0 &&
                     (((kind == K_ST || kind == K_STR) && ex == 4'd2) ||
                      (kind == K_CALL && ex == 4'd4));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0; mar <= '0; mdr <= '0; ir <= '0; t <= '0;
      zf <= 1'b0; sf <= 1'b0; step <= '0; halted <= 1'b0; cycle_count <= '0;
      for (int i = 0; i < NR; i++) rf[i] <= '0;
    end else if (!halted) begin
      cycle_count <= cycle_count + 1'b1;
      step <= nstep;
      case (step)
        4'd0: mar <= pc;
        4'd1: ;
        4'd2: begin ir <= mem_rdata; pc <= pc + 1'b1; end
        default:
          case (kind)
            K_LD: case (ex)
              4'd0: mar <= ads;
              4'd2: rf[ra] <= mem_rdata;
              default: ;
            endcase
            K_ST: case (ex)
              4'd0: mar <= ads;
              4'd1: mdr <= rf[ra];
              default: ;
            endcase
            K_JMP: if (ex == 4'd1 && take) pc <= ads;
            K_CALL: case (ex)
              4'd0: t <= rf[7] + 16'd1;
              4'd1: rf[7] <= t;
              4'd2: mar <= rf[7][AW-1:0];
              4'd3: mdr <= {{(16-AW){1'b0}}, pc};
              4'd5: begin pc <= ads; halted <= (ads == AW'(HALT_ADDR)); end
              default: ;
            endcase
            K_MOV: case (ex)
              4'd0: t <= rf[r1];
              4'd1: rf[r2] <= t;
              default: ;
            endcase
            K_LDR: case (ex)
              4'd0: mar <= rf[r1][AW-1:0];
              4'd2: rf[r2] <= mem_rdata;
              default: ;
            endcase
            K_STR: case (ex)
              4'd0: mdr <= rf[r1];
              4'd1: mar <= rf[r2][AW-1:0];
              default: ;
            endcase
            K_ADD, K_INC: case (ex)
              4'd0: t <= rf[r1] + ((kind == K_ADD) ? rf[r2] : 16'd1);
              4'd1: rf[r1] <= t;
              default: ;
            endcase
            K_CMP: begin zf <= (diff == 17'd0); sf <= diff[16]; end
            K_RET: case (ex)
              4'd0: mar <= rf[7][AW-1:0];
              4'd2: pc <= mem_rdata[AW-1:0];
              4'd3: t <= rf[7] - 16'd1;
              4'd4: rf[7] <= t;
              default: ;
            endcase
            K_JAL: case (ex)
              4'd0: mar <= pc;
              4'd2: begin
                rf[r1] <= {{(16-AW){1'b0}}, pc + 1'b1};
                pc <= mem_rdata[AW-1:0];
              end
              default: ;
            endcase
            K_JR: pc <= rf[r1][AW-1:0];
            default: ;
          endcase
      endcase
    end
  end
endmodule

module mc16_cpu_chk #(
  parameter int CW = 32
)(
  input logic          clk,
  input logic          rst,
  input logic          halted,
  input logic          mem_we,
  input logic [9:0]    mem_addr,
  input logic [CW-1:0] cycle_count,
  input logic [3:0]    step,
  input logic [9:0]    pc
);
  assert_count_step_R11: assert property (@(posedge clk) disable iff (rst)
    !halted |=> cycle_count == $past(cycle_count) + 1'b1);

  assert_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(cycle_count) && $stable(mem_addr));

  assert_no_write_halted_R10: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (step == 4'd0 && !halted) |=> mem_addr == $past(pc));

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
endmodule

bind mc16_cpu mc16_cpu_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .halted(halted), .mem_we(mem_we),
  .mem_addr(mem_addr), .cycle_count(cycle_count), .step(step), .pc(pc)
);

// File: tb/mc16_cpu_bench.sv
module mc16_cpu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we, halted;
  logic [31:0] cycle_count;

  always #2 clk = ~clk;

  mc16_cpu u_mc16_cpu (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .halted(halted),
    .cycle_count(cycle_count)
  );

  logic [15:0] mem [1024];
  logic [15:0] ref_mem [1024];

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  int compared = 0, mismatched = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pw(input int op, input int r, input int a);
    return {op[2:0], r[2:0], a[9:0]};
  endfunction
  function automatic logic [15:0] xw(input int xo, input int a, input int b);
    return {3'd7, xo[3:0], 3'd0, a[2:0], b[2:0]};
  endfunction

  task automatic put(input int a, input logic [15:0] w);
    mem[a] = w;
    ref_mem[a] = w;
  endtask

  // reference machine state
  logic [15:0] mr [8];
  logic [9:0]  mpc, fpc, waddr;
  logic [15:0] wdata;
  logic        mz, ms, halt_pend;
  int          len, woff;
  string       tag;

  function automatic bit cond(input logic [2:0] c);
    case (c)
      3'd0: return 1'b1;
      3'd1: return mz;
      3'd2: return !mz;
      3'd3: return ms;
      3'd4: return ms || mz;
      3'd5: return !ms;
      3'd6: return !ms && !mz;
      default: return 1'b0;
    endcase
  endfunction

  task automatic start_instr();
    logic [15:0] w, tg;
    logic [2:0] ra, a, b;
    logic [9:0] ads;
    w = ref_mem[mpc];
    fpc = mpc;
    mpc = mpc + 10'd1;
    ra = w[12:10]; ads = w[9:0]; a = w[5:3]; b = w[2:0];
    len = 3; woff = -1; tag = "R9";
    case (w[15:13])
      3'd0: begin len = 6; tag = "R3"; mr[ra] = ref_mem[ads]; end
      3'd1: begin len = 6; tag = "R3"; woff = 5; waddr = ads; wdata = mr[ra]; end
      3'd2: begin len = 5; tag = "R6"; if (cond(ra)) mpc = ads; end
      3'd3: begin
        len = 9; tag = "R7"; woff = 7;
        mr[7] = mr[7] + 16'd1;
        waddr = mr[7][9:0]; wdata = {6'd0, mpc};
        mpc = ads; halt_pend = (ads == 10'd1000);
      end
      3'd7: if (w[8:6] == 3'd0)
        case (w[12:9])
          4'd0: begin len = 5; tag = "R4"; mr[b] = mr[a]; end
          4'd1: begin len = 6; tag = "R5"; mr[b] = ref_mem[mr[a][9:0]]; end
          4'd2: begin len = 6; tag = "R5"; woff = 5; waddr = mr[b][9:0]; wdata = mr[a]; end
          4'd3: begin len = 5; tag = "R4"; mr[a] = mr[a] + mr[b]; end
          4'd4: begin
            len = 4; tag = "R6";
            mz = (mr[a] == mr[b]);
            ms = ($signed(mr[a]) < $signed(mr[b]));
          end
          4'd5: begin len = 5; tag = "R4"; mr[a] = mr[a] + 16'd1; end
          4'd6: begin
            len = 8; tag = "R7";
            mpc = ref_mem[mr[7][9:0]][9:0];
            mr[7] = mr[7] - 16'd1;
          end
          4'd7: begin
            len = 6; tag = "R8";
            tg = ref_mem[mpc];
            mr[a] = {6'd0, mpc + 10'd1};
            mpc = tg[9:0];
          end
          4'd8: begin len = 4; tag = "R8"; mpc = mr[a][9:0]; end
          default: ;
        endcase
      default: ;
    endcase
    if (woff >= 0) ref_mem[waddr] = wdata;
  endtask

  task automatic run_prog();
    int k, t, hc, guard;
    bit mhalt, done;
    for (int i = 0; i < 8; i++) mr[i] = '0;
    mpc = '0; mz = 1'b0; ms = 1'b0; halt_pend = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    k = 0; t = 0; hc = 0; guard = 0; mhalt = 1'b0; done = 1'b0;
    start_instr();
    while (!done) begin
      if (!mhalt) begin
        chk(cycle_count == 32'(t), (t == 0) ? "R1" : "R11", "cycle_count", cycle_count, t);
        chk(!halted, (t == 0) ? "R1" : "R10", "halted", halted, 0);
        chk(mem_we == (k == woff), tag, "mem_we", mem_we, (k == woff));
        if (k == woff) begin
          chk(mem_addr == waddr, tag, "write addr", mem_addr, waddr);
          chk(mem_wdata == wdata, tag, "write data", mem_wdata, wdata);
        end
        if (k == 1) chk(mem_addr == fpc, (t == 1) ? "R1" : "R2", "fetch addr", mem_addr, fpc);
        k++; t++;
        if (k == len) begin
          k = 0;
          if (halt_pend) mhalt = 1'b1;
          else start_instr();
        end
      end else begin
        chk(halted, "R10", "halted", halted, 1);
        chk(cycle_count == 32'(t), "R10", "frozen count", cycle_count, t);
        chk(!mem_we, "R10", "no write", mem_we, 0);
        hc++;
        if (hc == 4) done = 1'b1;
      end
      guard++;
      if (guard > 5000) begin
        chk(1'b0, "R11", "watchdog", guard, 0);
        done = 1'b1;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) put(i, 16'd0);
    put(0, pw(2, 0, 60));
    put(60, pw(0, 7, 48));
    put(61, pw(0, 1, 40));
    put(62, pw(0, 2, 41));
    put(63, pw(2, 0, 2));
    put(2, xw(4, 3, 1));
    put(3, pw(2, 5, 10));
    put(4, xw(0, 2, 5));
    put(5, xw(3, 5, 3));
    put(6, xw(1, 5, 6));
    put(7, xw(3, 4, 6));
    put(8, xw(5, 3, 0));
    put(9, pw(2, 0, 2));
    put(10, pw(1, 4, 43));
    put(11, pw(3, 0, 30));
    put(12, xw(7, 0, 0));
    put(13, 16'd25);
    put(14, xw(2, 4, 2));
    put(15, 16'h8000);
    put(16, xw(15, 0, 0));
    put(17, pw(2, 7, 0));
    put(18, pw(3, 0, 1000));
    put(25, pw(1, 0, 47));
    put(26, xw(8, 0, 0));
    put(30, pw(0, 1, 44));
    put(31, pw(0, 6, 45));
    put(32, xw(4, 1, 6));
    put(33, pw(2, 6, 35));
    put(34, pw(1, 1, 46));
    put(35, xw(6, 0, 0));
    put(40, 16'd5);
    put(41, 16'hFC32);
    put(44, 16'h7FFF);
    put(45, 16'h8000);
    put(48, 16'd300);
    put(50, 16'd3);
    put(51, 16'hFFF0);
    put(52, 16'd100);
    put(53, 16'd7);
    put(54, 16'd9);

    run_prog();
    chk(mem[43] == 16'd103, "R3", "sum stored", mem[43], 103);
    chk(mem[50] == 16'd103, "R5", "indirect store via high-bit base", mem[50], 103);
    chk(mem[46] == 16'd0, "R6", "overflowed compare taken GT", mem[46], 0);
    chk(mem[47] == 16'd14, "R8", "link value", mem[47], 14);
    chk(mem[301] == 16'd19, "R7", "stack slot", mem[301], 19);

    run_prog();
    chk(mem[43] == 16'd203, "R1", "second run after reset", mem[43], 203);
    for (int i = 0; i < 1024; i++)
      if (mem[i] != ref_mem[i]) chk(1'b0, "R3", "memory image", mem[i], ref_mem[i]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule